// File: doc/BRIEF.md
# Frame-Synchronous Shadow Register Bank

This block holds the configuration of a streaming video colour-conversion core as a bank of 32-bit words that software reaches through a plain memory-mapped port. The port has an address, write data, a write strobe and combinational read data. Software writes land in an *active* set. The datapath does not see that set. It sees a *shadow* set, and the shadow set copies the whole active set only on a start-of-frame pulse, and only while the update-enable control bit is set. Changes to clip limits, offsets, coefficients and frame size therefore take effect on a frame boundary and never partway through a picture.

The block also sequences two kinds of reset for the core, using a small state machine. Its states are `ST_RUN` (normal), `ST_HOLD` (immediate reset, kept while software leaves bit 31 set) and `ST_ARMED` (a synchronised reset is waiting for vertical blanking). Its transitions are:
- *enter-hold*: any state goes to `ST_HOLD` on a control write with bit 31 set.
- *arm*: `ST_RUN` goes to `ST_ARMED` on a control write with bit 30 set and bit 31 clear.
- *release*: `ST_HOLD` goes to `ST_RUN` on a control write with bits 31 and 30 clear.
- *release-to-arm*: `ST_HOLD` goes to `ST_ARMED` on a control write with bit 31 clear and bit 30 set.
- *fire*: `ST_ARMED` goes to `ST_RUN` on a rising edge of vertical blanking when no enter-hold write occurs in the same cycle. Fire restores the configuration and pulses the core reset for one cycle.

In any state, a control write matching none of the conditions above leaves the state unchanged.

Top module: `vcs_shadow_regs`

## Requirements
- R1: After `rst_n` is released, the control word reads 0 and `core_en_o` and `core_rst_o` are 0. The configuration words read as follows: active size 0x0500_02D0; every maximum 240; every minimum 16; Y offset 16; both chroma offsets 128; coefficients A=19595, B=7471, C=46727, D=36962. The shadow copies hold the same values.
- R2: The control word is at address 0x000. In it, bit 0 is core enable and bit 1 is update enable. `core_en_o` follows bit 0 from the cycle after the write. Bits 0 and 1 read back as written.
- R3: Address 0x020 holds the frame size, with columns in bits 31:16 and rows in bits 15:0. Words 0x100 to 0x130 are spaced 4 bytes apart and hold, in order: Y max, Y min, Cb max, Cb min, Cr max, Cr min, Y offset, Cb offset, Cr offset, A, B, C, D. On `cfg_shadow_o`, slot k sits at bits [32k+31:32k]. Slot 0 is the frame size, and slots 1 to 13 follow the 0x100 order.
- R4: A write to a configuration word is stored in the active set and is visible on the read port from the next cycle. Reads return the active value, even when the shadow copy differs.
- R5: The shadow set copies the entire active set at the clock edge where `frame_start_i` is 1 and update enable is 1. At every other edge, except a reset, it keeps its value.
- R6: Update enable does not clear itself. While it stays 1, every start-of-frame pulse reloads the shadow set.
- R7: A control write with bit 31 set asserts `core_rst_o` from the next cycle, and bit 31 then reads 1. From the following cycle, the active and shadow sets hold the R1 defaults, and configuration writes are discarded. This lasts until a control write clears bit 31.
- R8: A control write with bit 30 set arms a synchronised reset, and bit 30 reads 1 while it is armed. The reset fires at the first clock edge where `vblank_i` is 1 after having been 0 at the previous edge. At that edge, the active and shadow sets return to the R1 defaults and bit 30 clears. `core_rst_o` is 1 for exactly the following cycle.
- R9: An armed reset does not fire while `vblank_i` stays at a high level that was already present when it was armed. It needs a fresh low-to-high transition.
- R10: Address 0x010 returns the `VERSION` parameter and ignores writes. Every other address outside R2 and R3 reads 0 and ignores writes, including 0x004, 0x008, 0x00C and 0x134.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| frame_start_i | input | 1 | One-cycle start-of-frame pulse |
| vblank_i | input | 1 | Vertical blanking level |
| core_en_o | output | 1 | Core enable to the datapath |
| core_rst_o | output | 1 | Reset to the datapath |
| cfg_shadow_o | output | 14*32 | Shadow configuration, slot layout as in R3 |

## Verification
The bench builds the block with `ADDR_W` = 12 and a distinctive `VERSION` of 0xC0DE_0042. The 12-bit address reaches every mapped word and the unmapped space just past 0x130. The non-default version value shows that the read port returns the parameter and not a hard-coded constant. Most checks look at `cfg_shadow_o`. They confirm that a written value reaches the shadow set only at the frame pulse, and that the R3 slot order holds. The reset checks are placed cycle by cycle: the one-cycle fire pulse is sampled in the only cycle it can be high, and again in the cycle after.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
    // number of configuration words (frame size + 13 per-channel words)
    localparam int NCFG      = 14;
    localparam int CFG_IDX_W = $clog2(NCFG);
    localparam int CTRL_OFS  = 'h000;
    localparam int VER_OFS   = 'h010;
    localparam int SIZE_OFS  = 'h020;
    localparam int CHAN_BASE = 'h100;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_ARMED = 2'd2
    } rst_state_e;

    function automatic logic [31:0] cfg_default(input int slot);
        logic [31:0] v;
        case (slot)
            0:          v = 32'h0500_02D0;
            1, 3, 5:    v = 32'd240;
            2, 4, 6, 7: v = 32'd16;
            8, 9:       v = 32'd128;
            10:         v = 32'd19595;
            11:         v = 32'd7471;
            12:         v = 32'd46727;
            13:         v = 32'd36962;
            default:    v = 32'd0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/vcs_addr_dec.sv
module vcs_addr_dec
    import vcs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output logic                 is_ctrl_o,
    output logic                 is_ver_o,
    output logic                 cfg_hit_o,
    output logic [CFG_IDX_W-1:0] cfg_idx_o
);
    localparam int WORD_W = ADDR_W - 2;

    logic [ADDR_W-1:0] off;
    logic              size_hit;
    logic              chan_hit;

    always_comb begin
        off       = addr_i - ADDR_W'(CHAN_BASE);
        is_ctrl_o = (addr_i == ADDR_W'(CTRL_OFS));
        is_ver_o  = (addr_i == ADDR_W'(VER_OFS));
        size_hit  = (addr_i == ADDR_W'(SIZE_OFS));
        chan_hit  = (addr_i >= ADDR_W'(CHAN_BASE))
                 && (off[ADDR_W-1:2] < WORD_W'(NCFG - 1))
                 && (off[1:0] == 2'b00);
        cfg_hit_o = size_hit || chan_hit;
        cfg_idx_o = size_hit ? '0
                  : CFG_IDX_W'(off[ADDR_W-1:2]) + CFG_IDX_W'(1);
    end
endmodule

// File: rtl/vcs_reset_fsm.sv
module vcs_reset_fsm
    import vcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we_i,
    input  logic       wr_imm_i,
    input  logic       wr_auto_i,
    input  logic       vblank_i,
    output rst_state_e state_o,
    output logic       cfg_clear_o,
    output logic       core_rst_o
);
    rst_state_e st, nxt;
    logic       vb_prev;
    logic       vb_rise;
    logic       fire;
    logic       pulse_q;

    assign vb_rise = vblank_i && !vb_prev;

    always_comb begin
        nxt  = st;
        fire = 1'b0;
        unique case (st)
            ST_RUN: begin
                if (ctrl_we_i && wr_imm_i)       nxt = ST_HOLD;
                else if (ctrl_we_i && wr_auto_i) nxt = ST_ARMED;
            end
            ST_HOLD: begin
                if (ctrl_we_i && !wr_imm_i)      nxt = wr_auto_i ? ST_ARMED : ST_RUN;
            end
            ST_ARMED: begin
                if (ctrl_we_i && wr_imm_i) begin
                    nxt = ST_HOLD;
                end else if (vb_rise) begin
                    nxt  = ST_RUN;
                    fire = 1'b1;
                end
            end
            default: nxt = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_RUN;
            vb_prev <= 1'b0;
        end else begin
            st      <= nxt;
            vb_prev <= vblank_i;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= fire;
    end

    assign state_o     = st;
    assign cfg_clear_o = (st == ST_HOLD) || fire;
    assign core_rst_o  = (st == ST_HOLD) || pulse_q;

    // R7
    hold_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> core_rst_o);
    // R8
    armed_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && vblank_i && !vb_prev && !(ctrl_we_i && wr_imm_i))
        |=> (st == ST_RUN && core_rst_o));
    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
    // R9
    no_level_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && vb_prev && !ctrl_we_i) |=> (st == ST_ARMED));
endmodule

// File: rtl/vcs_cfg_bank.sv
module vcs_cfg_bank
    import vcs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear_i,
    input  logic                   we_i,
    input  logic [CFG_IDX_W-1:0]   widx_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic                   load_i,
    output logic [NCFG*DATA_W-1:0] active_o,
    output logic [NCFG*DATA_W-1:0] shadow_o
);
    for (genvar i = 0; i < NCFG; i++) begin : g_slot
        localparam logic [DATA_W-1:0] DEF = DATA_W'(cfg_default(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                active_o[i*DATA_W +: DATA_W] <= DEF;
            else if (clear_i)
                active_o[i*DATA_W +: DATA_W] <= DEF;
            else if (we_i && (widx_i == CFG_IDX_W'(i)))
                active_o[i*DATA_W +: DATA_W] <= wdata_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shadow_o[i*DATA_W +: DATA_W] <= DEF;
            else if (clear_i)
                shadow_o[i*DATA_W +: DATA_W] <= DEF;
            else if (load_i)
                shadow_o[i*DATA_W +: DATA_W] <= active_o[i*DATA_W +: DATA_W];
        end
    end

    // R5
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !load_i) |=> $stable(shadow_o));
    // R5
    shadow_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && load_i) |=> (shadow_o == $past(active_o)));
endmodule

// File: rtl/vcs_shadow_regs.sv
module vcs_shadow_regs
    import vcs_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter int          DATA_W  = 32,
    parameter logic [31:0] VERSION = 32'h0001_0000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr_i,
    input  logic [DATA_W-1:0]      bus_wdata_i,
    input  logic                   bus_we_i,
    output logic [DATA_W-1:0]      bus_rdata_o,
    input  logic                   frame_start_i,
    input  logic                   vblank_i,
    output logic                   core_en_o,
    output logic                   core_rst_o,
    output logic [NCFG*DATA_W-1:0] cfg_shadow_o
);
    logic                   is_ctrl, is_ver, cfg_hit;
    logic [CFG_IDX_W-1:0]   cfg_idx;
    logic                   en_q, upd_q;
    logic                   cfg_clear;
    rst_state_e             rst_state;
    logic [NCFG*DATA_W-1:0] active_flat;

    vcs_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i    (bus_addr_i),
        .is_ctrl_o (is_ctrl),
        .is_ver_o  (is_ver),
        .cfg_hit_o (cfg_hit),
        .cfg_idx_o (cfg_idx)
    );

    vcs_reset_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we_i   (bus_we_i && is_ctrl),
        .wr_imm_i    (bus_wdata_i[31]),
        .wr_auto_i   (bus_wdata_i[30]),
        .vblank_i    (vblank_i),
        .state_o     (rst_state),
        .cfg_clear_o (cfg_clear),
        .core_rst_o  (core_rst_o)
    );

    vcs_cfg_bank #(.DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (cfg_clear),
        .we_i     (bus_we_i && cfg_hit),
        .widx_i   (cfg_idx),
        .wdata_i  (bus_wdata_i),
        .load_i   (frame_start_i && upd_q),
        .active_o (active_flat),
        .shadow_o (cfg_shadow_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            upd_q <= 1'b0;
        end else if (bus_we_i && is_ctrl) begin
            en_q  <= bus_wdata_i[0];
            upd_q <= bus_wdata_i[1];
        end
    end

    assign core_en_o = en_q;

    always_comb begin
        bus_rdata_o = '0;
        if (is_ctrl) begin
            bus_rdata_o[31] = (rst_state == ST_HOLD);
            bus_rdata_o[30] = (rst_state == ST_ARMED);
            bus_rdata_o[1]  = upd_q;
            bus_rdata_o[0]  = en_q;
        end else if (is_ver) begin
            bus_rdata_o = DATA_W'(VERSION);
        end else if (cfg_hit) begin
            bus_rdata_o = active_flat[int'(cfg_idx)*DATA_W +: DATA_W];
        end
    end

    // R2
    core_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == '0) |=> (core_en_o == $past(bus_wdata_i[0])));
endmodule

// File: tb/tb_vcs_shadow_regs.sv
module tb_vcs_shadow_regs;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 12;
    localparam int NSLOT  = 14;
    localparam int K_RD   = 0;
    localparam int K_SH   = 1;
    localparam int K_RST  = 2;
    localparam int K_EN   = 3;
    localparam logic [31:0] VER = 32'hC0DE_0042;

    typedef struct {
        int          kind;
        int          sel;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [ADDR_W-1:0]     bus_addr = '0;
    logic [31:0]           bus_wdata = '0;
    logic                  bus_we = 1'b0;
    logic [31:0]           bus_rdata;
    logic                  frame_start = 1'b0;
    logic                  vblank = 1'b0;
    logic                  core_en, core_rst;
    logic [NSLOT*32-1:0]   cfg_shadow;

    item_t q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    vcs_shadow_regs #(.ADDR_W(ADDR_W), .DATA_W(32), .VERSION(VER)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr_i    (bus_addr),
        .bus_wdata_i   (bus_wdata),
        .bus_we_i      (bus_we),
        .bus_rdata_o   (bus_rdata),
        .frame_start_i (frame_start),
        .vblank_i      (vblank),
        .core_en_o     (core_en),
        .core_rst_o    (core_rst),
        .cfg_shadow_o  (cfg_shadow)
    );

    always #(CLK_P/2) clk = ~clk;

    // every driver task owns one clock cycle, starting at a falling edge
    task automatic cyc_start();
        @(negedge clk);
        bus_we      = 1'b0;
        frame_start = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        cyc_start();
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
    endtask

    task automatic idle();
        cyc_start();
    endtask

    task automatic pulse_frame();
        cyc_start();
        frame_start = 1'b1;
    endtask

    task automatic set_vb(input logic v);
        cyc_start();
        vblank = v;
    endtask

    task automatic expect_item(input int kind, input int sel, input logic [31:0] exp,
                               input string req);
        item_t it;
        cyc_start();
        if (kind == K_RD) bus_addr = ADDR_W'(sel);
        it.kind = kind;
        it.sel  = sel;
        it.exp  = exp;
        it.req  = req;
        q.push_back(it);
    endtask

    // monitor: compares queued expectations shortly after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    K_RD:    act = bus_rdata;
                    K_SH:    act = cfg_shadow[it.sel*32 +: 32];
                    K_RST:   act = {31'b0, core_rst};
                    default: act = {31'b0, core_en};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: kind %0d sel 0x%0h actual 0x%08h expected 0x%08h",
                             it.req, it.kind, it.sel, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_item(K_RD, 'h000, 32'h0, "R1 ctrl");
        expect_item(K_RD, 'h124, 32'd19595, "R1 coef A");
        expect_item(K_RD, 'h130, 32'd36962, "R1 coef D");
        expect_item(K_RD, 'h118, 32'd16, "R1 y offset");
        expect_item(K_RD, 'h11C, 32'd128, "R1 cb offset");
        expect_item(K_RD, 'h110, 32'd240, "R1 cr max");
        expect_item(K_RD, 'h114, 32'd16, "R1 cr min");
        expect_item(K_RD, 'h020, 32'h0500_02D0, "R1 size");
        expect_item(K_SH, 10, 32'd19595, "R1 shadow A");
        expect_item(K_EN, 0, 32'd0, "R1 core_en");
        expect_item(K_RST, 0, 32'd0, "R1 core_rst");

        // R10 version and reserved words
        expect_item(K_RD, 'h010, VER, "R10 version");
        expect_item(K_RD, 'h004, 32'h0, "R10 status word");

        // R4 / R5 write with update disabled
        wr('h124, 32'd1000);
        expect_item(K_RD, 'h124, 32'd1000, "R4 readback");
        pulse_frame();
        expect_item(K_SH, 10, 32'd19595, "R5 no load while update off");

        // R2 control
        wr('h000, 32'h3);
        expect_item(K_EN, 0, 32'd1, "R2 core_en");
        expect_item(K_RD, 'h000, 32'h3, "R2 ctrl readback");
        expect_item(K_SH, 10, 32'd19595, "R5 no load without frame start");
        pulse_frame();
        expect_item(K_SH, 10, 32'd1000, "R5 load at frame start");

        // R6 update stays set
        wr('h124, 32'd2000);
        pulse_frame();
        expect_item(K_SH, 10, 32'd2000, "R6 second reload");
        expect_item(K_RD, 'h000, 32'h3, "R6 update bit kept");

        // R3 map and slot layout
        wr('h020, 32'h0780_0438);
        wr('h114, 32'h22);
        pulse_frame();
        expect_item(K_SH, 0, 32'h0780_0438, "R3 size slot");
        expect_item(K_SH, 6, 32'h22, "R3 cr min slot");
        expect_item(K_SH, 1, 32'd240, "R3 y max slot");
        expect_item(K_RD, 'h020, 32'h0780_0438, "R3 size readback");

        // R4 reads return active, not shadow
        wr('h124, 32'd3000);
        expect_item(K_RD, 'h124, 32'd3000, "R4 active read");
        expect_item(K_SH, 10, 32'd2000, "R4 shadow differs");

        // R10 unmapped and read-only
        wr('h134, 32'hFFFF);
        expect_item(K_RD, 'h134, 32'h0, "R10 unmapped read");
        wr('h010, 32'h0);
        expect_item(K_RD, 'h010, VER, "R10 version write ignored");
        wr('h008, 32'h5);
        expect_item(K_RD, 'h008, 32'h0, "R10 error word");

        // R7 immediate reset
        wr('h000, 32'h8000_0003);
        expect_item(K_RST, 0, 32'd1, "R7 core_rst asserted");
        expect_item(K_RD, 'h000, 32'h8000_0003, "R7 bit31 reads 1");
        expect_item(K_RD, 'h124, 32'd19595, "R7 active default");
        wr('h124, 32'd5);
        expect_item(K_RD, 'h124, 32'd19595, "R7 write ignored in hold");
        expect_item(K_SH, 10, 32'd19595, "R7 shadow default");
        expect_item(K_SH, 0, 32'h0500_02D0, "R7 size shadow default");
        expect_item(K_RST, 0, 32'd1, "R7 still held");
        wr('h000, 32'h3);
        expect_item(K_RST, 0, 32'd0, "R7 released");
        expect_item(K_RD, 'h000, 32'h3, "R7 ctrl after release");

        // R8 auto-synchronised reset
        wr('h124, 32'd777);
        pulse_frame();
        expect_item(K_SH, 10, 32'd777, "R8 setup load");
        wr('h000, 32'h4000_0003);
        expect_item(K_RD, 'h000, 32'h4000_0003, "R8 armed reads bit30");
        expect_item(K_RST, 0, 32'd0, "R8 no reset while armed");
        set_vb(1'b1);
        expect_item(K_RST, 0, 32'd1, "R8 pulse cycle");
        expect_item(K_RST, 0, 32'd0, "R8 pulse one cycle");
        expect_item(K_RD, 'h124, 32'd19595, "R8 active default");
        expect_item(K_SH, 10, 32'd19595, "R8 shadow default");
        expect_item(K_RD, 'h000, 32'h3, "R8 bit30 cleared");

        // R9 arm while vblank already high
        wr('h124, 32'd777);
        pulse_frame();
        wr('h000, 32'h4000_0003);
        idle();
        idle();
        expect_item(K_RST, 0, 32'd0, "R9 no fire on level");
        expect_item(K_RD, 'h124, 32'd777, "R9 config kept");
        expect_item(K_RD, 'h000, 32'h4000_0003, "R9 still armed");
        set_vb(1'b0);
        idle();
        set_vb(1'b1);
        expect_item(K_RST, 0, 32'd1, "R9 fires on fresh edge");
        expect_item(K_RD, 'h000, 32'h3, "R9 disarmed");

        idle();
        idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule